// File: doc/BRIEF.md
# Per-Bank Refresh Sequencer

This block decides which bank of an eight-bank DRAM receives the next single-bank refresh and walks that refresh through to completion. A refresh timing tracker sends a one-cycle strobe each time a refresh falls due. The sequencer then picks a bank that has not yet been refreshed in the current round. It waits while the controller core is using that bank, blocks the bank from new accesses, raises a refresh request carrying the bank index, and releases the bank once the refresh is acknowledged.

Each bank is refreshed exactly once per round before any bank may be refreshed again. The bank order is either strictly ascending or free. In free order the sequencer prefers a bank the core is not using, so one active bank does not hold up refresh of the others. If a chosen bank stays busy longer than a programmable limit, the sequencer preempts the core. It inhibits the core, asks for the bank to be closed, refreshes the bank and then lifts the inhibit so the interrupted work can continue.

Top module: `bankref_sequencer`

## Requirements
- R1: A synchronous active-high reset drives `refresh_req`, `core_inhibit`, `close_req` and `block_mask` low, forgets any pending strobe and empties the round record, so the first refresh after reset may target any bank.
- R2: Within a round, each of the 8 banks is refreshed exactly once. The acknowledgement of the eighth distinct bank empties the round record, and the next refresh starts a new round.
- R3: With `free_order` = 0, the banks are refreshed in ascending order 0,1,...,7 in every round, whatever `bank_busy` holds.
- R4: With `free_order` = 1, the chosen bank is the lowest-index bank that is unrefreshed in this round and whose `bank_busy` bit is 0. If every unrefreshed bank is busy, the lowest-index unrefreshed bank is chosen. Bit i of `bank_busy` belongs to bank i.
- R5: A new selection starts only while both `bank_ref_en` and `ref_en` are 1. A strobe that arrives while either enable is low is remembered and is served once both are high.
- R6: While the selected bank's busy bit is 1, no refresh request is raised. The wait count restarts at zero for every newly selected bank.
- R7: Let M be `max_wait`. If the selected bank is still busy on the (M+1)-th clock edge after the selection edge, `core_inhibit` and `close_req` rise together on that edge. `close_req` falls on the edge that samples `close_done`. `core_inhibit` stays high until the refresh is acknowledged.
- R8: `refresh_req` and the one-hot bit of `block_mask` for the selected bank (bit i = bank i) rise together. This happens `sel_delay`+1 edges after the edge on which the bank is first seen free, or after the edge that samples `close_done`.
- R9: `refresh_req` stays high with a stable `refresh_bank` (binary bank index) until `refresh_done` is sampled. On that edge `refresh_req`, `block_mask` and `core_inhibit` all fall. Only one refresh is outstanding at a time.
- R10: Refresh-due strobes are held one deep. A strobe that arrives while a refresh is in progress, including in the same cycle as `refresh_done`, is served after that refresh without a further strobe. Extra strobes beyond one are merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_ref_en | input | 1 | Enables single-bank refresh |
| ref_en | input | 1 | Global refresh enable |
| free_order | input | 1 | 0: ascending order, 1: free order preferring idle banks |
| max_wait | input | 16 | Busy cycles tolerated before preempting the core |
| sel_delay | input | 4 | Clocks between bank free and access block |
| refresh_due | input | 1 | One-cycle strobe: a refresh is due |
| bank_busy | input | 8 | Bank i is in use by the core |
| close_done | input | 1 | Core reports the requested bank is closed |
| refresh_done | input | 1 | Refresh of the requested bank is complete |
| refresh_req | output | 1 | Refresh request for `refresh_bank` |
| refresh_bank | output | 3 | Index of the bank being served |
| core_inhibit | output | 1 | Stalls the core during a forced refresh |
| close_req | output | 1 | Asks the core to close `refresh_bank` |
| block_mask | output | 8 | One-hot access block, bit i = bank i |

## Verification
Two events can meet on the same edge: the acknowledgement that ends one refresh, and a new due strobe. The bench raises `refresh_done` and `refresh_due` in the same cycle. It then expects the request to drop on that edge and a fresh request for the next bank to rise exactly three edges later with no further strobe. After that, it expects nothing more. A lost or doubled strobe therefore shows up as a missing or extra request at the ports.

// File: rtl/bankref_pkg.sv
`timescale 1ns/1ps
package bankref_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_CLOSE = 3'd2,
    ST_DELAY = 3'd3,
    ST_ISSUE = 3'd4
  } seq_state_e;
endpackage

// File: rtl/bankref_counter.sv
`timescale 1ns/1ps
module bankref_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc && (cnt != {W{1'b1}}))
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bankref_picker.sv
`timescale 1ns/1ps
module bankref_picker #(
  parameter int NB = 8,
  parameter int IW = $clog2(NB)
) (
  input  logic [NB-1:0] done_mask,
  input  logic [NB-1:0] busy,
  input  logic          free_order,
  output logic [IW-1:0] pick,
  output logic          pick_ok
);
  logic [NB-1:0] open_set;
  logic [NB-1:0] idle_set;
  logic [NB-1:0] use_set;

  always_comb begin
    open_set = ~done_mask;
    idle_set = open_set & ~busy;
    use_set  = (free_order && (|idle_set)) ? idle_set : open_set;
    pick_ok  = |use_set;
    pick     = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (use_set[i]) pick = IW'(i);
    end
  end
endmodule

// File: rtl/bankref_round.sv
`timescale 1ns/1ps
module bankref_round #(
  parameter int NB = 8,
  parameter int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mark,
  input  logic [IW-1:0] mark_idx,
  output logic [NB-1:0] done_mask
);
  localparam logic [NB-1:0] ONE  = NB'(1);
  localparam logic [NB-1:0] FULL = {NB{1'b1}};

  logic [NB-1:0] nxt_mask;
  assign nxt_mask = done_mask | (ONE << mark_idx);

  always_ff @(posedge clk) begin
    if (rst)
      done_mask <= '0;
    else if (mark)
      done_mask <= (nxt_mask == FULL) ? '0 : nxt_mask;
  end

  // R2: a bank is never marked twice within one round
  p_single_visit_r2: assert property (@(posedge clk) disable iff (rst)
    mark |-> !done_mask[mark_idx]);
endmodule

// File: rtl/bankref_sequencer.sv
`timescale 1ns/1ps
module bankref_sequencer #(
  parameter int NUM_BANKS = 8,
  parameter int WAIT_W    = 16,
  parameter int DLY_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bank_ref_en,
  input  logic                         ref_en,
  input  logic                         free_order,
  input  logic [WAIT_W-1:0]            max_wait,
  input  logic [DLY_W-1:0]             sel_delay,
  input  logic                         refresh_due,
  input  logic [NUM_BANKS-1:0]         bank_busy,
  input  logic                         close_done,
  input  logic                         refresh_done,
  output logic                         refresh_req,
  output logic [$clog2(NUM_BANKS)-1:0] refresh_bank,
  output logic                         core_inhibit,
  output logic                         close_req,
  output logic [NUM_BANKS-1:0]         block_mask
);
  import bankref_pkg::*;

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam logic [NUM_BANKS-1:0] ONE = NUM_BANKS'(1);

  seq_state_e            state;
  logic                  pend;
  logic [BANK_W-1:0]     sel_bank;
  logic [NUM_BANKS-1:0]  done_mask;
  logic [BANK_W-1:0]     pick;
  logic                  pick_ok;
  logic [WAIT_W-1:0]     wait_cnt;
  logic [DLY_W-1:0]      dly_cnt;
  logic                  start;
  logic                  sel_busy;
  logic                  mark;

  assign sel_busy = bank_busy[sel_bank];
  assign start    = (state == ST_IDLE) && bank_ref_en && ref_en &&
                    (pend || refresh_due) && pick_ok;
  assign mark     = (state == ST_ISSUE) && refresh_done;

  bankref_picker #(.NB(NUM_BANKS), .IW(BANK_W)) u_picker (
    .done_mask  (done_mask),
    .busy       (bank_busy),
    .free_order (free_order),
    .pick       (pick),
    .pick_ok    (pick_ok)
  );

  bankref_round #(.NB(NUM_BANKS), .IW(BANK_W)) u_round (
    .clk       (clk),
    .rst       (rst),
    .mark      (mark),
    .mark_idx  (sel_bank),
    .done_mask (done_mask)
  );

  bankref_counter #(.W(WAIT_W)) u_wait (
    .clk (clk),
    .rst (rst),
    .clr (start),
    .inc ((state == ST_HOLD) && sel_busy && (wait_cnt != max_wait)),
    .cnt (wait_cnt)
  );

  bankref_counter #(.W(DLY_W)) u_delay (
    .clk (clk),
    .rst (rst),
    .clr (state != ST_DELAY),
    .inc ((state == ST_DELAY) && (dly_cnt != sel_delay)),
    .cnt (dly_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      pend         <= 1'b0;
      sel_bank     <= '0;
      refresh_req  <= 1'b0;
      core_inhibit <= 1'b0;
      close_req    <= 1'b0;
      block_mask   <= '0;
    end else begin
      pend <= (pend | refresh_due) & ~start;
      case (state)
        ST_IDLE: begin
          if (start) begin
            sel_bank <= pick;
            state    <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (!sel_busy) begin
            state <= ST_DELAY;
          end else if (wait_cnt == max_wait) begin
            core_inhibit <= 1'b1;
            close_req    <= 1'b1;
            state        <= ST_CLOSE;
          end
        end
        ST_CLOSE: begin
          if (close_done) begin
            close_req <= 1'b0;
            state     <= ST_DELAY;
          end
        end
        ST_DELAY: begin
          if (dly_cnt == sel_delay) begin
            refresh_req <= 1'b1;
            block_mask  <= ONE << sel_bank;
            state       <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (refresh_done) begin
            refresh_req  <= 1'b0;
            block_mask   <= '0;
            core_inhibit <= 1'b0;
            state        <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign refresh_bank = sel_bank;

  // R3: ascending order means all lower banks are already done this round
  p_numeric_order_r3: assert property (@(posedge clk) disable iff (rst)
    (start && !free_order) |->
      ((done_mask & ((ONE << pick) - ONE)) == ((ONE << pick) - ONE)));

  // R4: free order never picks a busy bank while an idle open bank exists
  p_free_prefers_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (start && free_order && |(~done_mask & ~bank_busy)) |-> !bank_busy[pick]);

  // R5: no selection leaves idle while an enable is low
  p_enable_gate_r5: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && !(bank_ref_en && ref_en)) |=> (state == ST_IDLE));

  // R7: inhibit only rises after the full wait on a busy bank
  p_inhibit_after_wait_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(core_inhibit) |-> $past((wait_cnt == max_wait) && sel_busy));

  // R7: close requests only happen under inhibit
  p_close_under_inhibit_r7: assert property (@(posedge clk) disable iff (rst)
    close_req |-> core_inhibit);

  // R8: an issued refresh always has exactly its own bank blocked
  p_req_blocked_r8: assert property (@(posedge clk) disable iff (rst)
    refresh_req |-> (block_mask == (ONE << refresh_bank)));

  // R9: request holds steady until acknowledged
  p_req_held_r9: assert property (@(posedge clk) disable iff (rst)
    (refresh_req && !refresh_done) |=> (refresh_req && $stable(refresh_bank)));

  // R9: at most one bank blocked at any time
  p_one_block_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(block_mask));
endmodule

// File: tb/bankref_sequencer_bench.sv
`timescale 1ns/1ps
module bankref_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bank_ref_en = 1'b1;
  logic       ref_en = 1'b1;
  logic       free_order = 1'b0;
  logic [15:0] max_wait = 16'd100;
  logic [3:0] sel_delay = 4'd0;
  logic       refresh_due = 1'b0;
  logic [7:0] bank_busy = 8'h00;
  logic       close_done = 1'b0;
  logic       refresh_done = 1'b0;
  logic       refresh_req;
  logic [2:0] refresh_bank;
  logic       core_inhibit;
  logic       close_req;
  logic [7:0] block_mask;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bankref_sequencer u_bankref_sequencer (
    .clk (clk), .rst (rst), .bank_ref_en (bank_ref_en), .ref_en (ref_en),
    .free_order (free_order), .max_wait (max_wait), .sel_delay (sel_delay),
    .refresh_due (refresh_due), .bank_busy (bank_busy),
    .close_done (close_done), .refresh_done (refresh_done),
    .refresh_req (refresh_req), .refresh_bank (refresh_bank),
    .core_inhibit (core_inhibit), .close_req (close_req),
    .block_mask (block_mask)
  );

  // {free_order, bank_busy[7:0], expected bank[2:0]}
  localparam logic [11:0] VEC [17] = '{
    {1'b1, 8'b0000_0001, 3'd1}, {1'b1, 8'b0000_0110, 3'd0},
    {1'b1, 8'b1111_1100, 3'd2}, {1'b1, 8'b0010_1000, 3'd4},
    {1'b1, 8'b0000_0000, 3'd3}, {1'b1, 8'b1010_0000, 3'd6},
    {1'b1, 8'b0010_0000, 3'd7}, {1'b1, 8'b0000_0000, 3'd5},
    {1'b0, 8'b0000_0001, 3'd0}, {1'b0, 8'b1111_1111, 3'd1},
    {1'b0, 8'b0000_0100, 3'd2}, {1'b0, 8'b0000_0000, 3'd3},
    {1'b0, 8'b1111_0000, 3'd4}, {1'b0, 8'b0010_0000, 3'd5},
    {1'b0, 8'b0100_0000, 3'd6}, {1'b0, 8'b1000_0000, 3'd7},
    {1'b1, 8'b0000_0001, 3'd1}
  };

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // strobe sampled on edge E; returns 1 ns after E
  task automatic start_refresh();
    @(negedge clk);
    refresh_due = 1'b1;
    edge_step();
    refresh_due = 1'b0;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!refresh_req && n < 100) begin
      edge_step();
      n++;
    end
  endtask

  task automatic finish_ref(input string tag);
    refresh_done = 1'b1;
    edge_step();
    refresh_done = 1'b0;
    check(tag, "req after done", int'(refresh_req), 0);
    check(tag, "block after done", int'(block_mask), 0);
    check(tag, "inhibit after done", int'(core_inhibit), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    #1;
    // R1: reset state at the ports
    check("R1", "refresh_req", int'(refresh_req), 0);
    check("R1", "core_inhibit", int'(core_inhibit), 0);
    check("R1", "close_req", int'(close_req), 0);
    check("R1", "block_mask", int'(block_mask), 0);

    // R2 R3 R4 R9: table walk over two rounds plus the start of a third
    for (int i = 0; i < 17; i++) begin
      free_order = VEC[i][11];
      bank_busy  = VEC[i][10:3];
      start_refresh();
      bank_busy = 8'h00;
      wait_req(n);
      check(VEC[i][11] ? "R4" : "R3", "chosen bank", int'(refresh_bank), int'(VEC[i][2:0]));
      check("R2", "request seen", int'(refresh_req), 1);
      finish_ref("R9");
    end

    // R8: select delay timing
    do_reset();
    free_order = 1'b0;
    sel_delay  = 4'd5;
    start_refresh();
    wait_req(n);
    check("R8", "edges to request, delay 5", n, 7);
    check("R8", "block bit bank 0", int'(block_mask), 1);
    finish_ref("R8");
    sel_delay = 4'd0;
    start_refresh();
    wait_req(n);
    check("R8", "edges to request, delay 0", n, 2);
    check("R8", "block bit bank 1", int'(block_mask), 2);
    finish_ref("R8");

    // R5: enable gating with remembered strobe
    bank_ref_en = 1'b0;
    start_refresh();
    repeat (10) edge_step();
    check("R5", "no request, bank enable low", int'(refresh_req), 0);
    bank_ref_en = 1'b1;
    wait_req(n);
    check("R5", "served after enable", int'(refresh_req), 1);
    check("R5", "bank after enable", int'(refresh_bank), 2);
    finish_ref("R5");
    ref_en = 1'b0;
    start_refresh();
    repeat (10) edge_step();
    check("R5", "no request, global enable low", int'(refresh_req), 0);
    ref_en = 1'b1;
    wait_req(n);
    check("R5", "bank after global enable", int'(refresh_bank), 3);
    finish_ref("R5");

    // R6: hold-off while busy, then normal issue
    bank_busy = 8'h10;
    start_refresh();
    repeat (6) edge_step();
    check("R6", "no request while busy", int'(refresh_req), 0);
    check("R6", "no inhibit under limit", int'(core_inhibit), 0);
    bank_busy = 8'h00;
    wait_req(n);
    check("R6", "edges after free", n, 2);
    check("R6", "bank 4 served", int'(refresh_bank), 4);
    finish_ref("R6");

    // R10: done and due in the same cycle
    start_refresh();
    wait_req(n);
    check("R10", "bank 5 issued", int'(refresh_bank), 5);
    refresh_done = 1'b1;
    refresh_due  = 1'b1;
    edge_step();
    refresh_done = 1'b0;
    refresh_due  = 1'b0;
    check("R10", "request dropped", int'(refresh_req), 0);
    wait_req(n);
    check("R10", "edges to pended request", n, 3);
    check("R10", "pended bank", int'(refresh_bank), 6);
    finish_ref("R10");
    repeat (10) edge_step();
    check("R10", "no extra request", int'(refresh_req), 0);

    // R7 and R6: forced preemption, counter restarted per bank
    do_reset();
    free_order = 1'b0;
    max_wait   = 16'd3;
    bank_busy  = 8'hFF;
    for (int b = 0; b < 2; b++) begin
      start_refresh();
      n = 0;
      while (!core_inhibit && n < 50) begin
        edge_step();
        n++;
      end
      check(b == 0 ? "R7" : "R6", "edges to inhibit", n, 4);
      check("R7", "close_req with inhibit", int'(close_req), 1);
      check("R7", "no request before close", int'(refresh_req), 0);
      repeat (3) edge_step();
      check("R7", "close_req held", int'(close_req), 1);
      close_done = 1'b1;
      edge_step();
      close_done = 1'b0;
      check("R7", "close_req released", int'(close_req), 0);
      check("R7", "inhibit held", int'(core_inhibit), 1);
      edge_step();
      check("R8", "request after close", int'(refresh_req), 1);
      check("R7", "forced bank", int'(refresh_bank), b);
      check("R7", "inhibit during refresh", int'(core_inhibit), 1);
      finish_ref("R7");
    end
    bank_busy = 8'h00;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule